// File: doc/BRIEF.md
# Thermal Trip Monitor

This block watches the digitised readings of several temperature sensors and flags two levels of over-temperature per channel. Each channel delivers a code together with a one-cycle valid strobe. The sensor code gets smaller as the die gets hotter. A hot condition therefore means the code is at or below a threshold, and every comparison here is an unsigned less-or-equal test.

Every channel has three programmable 12-bit levels: an alarm trip level, a release (hysteresis) level and a shutdown trip level. The alarm keeps one bit of state per channel. It trips when a sample reaches the alarm level and clears only when a later sample climbs above the release level. A status bit is recorded only when the alarm trips, not while it stays tripped. The shutdown check keeps no state, so every sample at or below its level records status. Status bits are sticky and are cleared by writing a 1. A per-bit enable mask gates them onto a single interrupt line.

Software reaches the levels, status and mask through a simple word-wide register port. The port has a write strobe and an address, and its read data follows the address in the same cycle.

Top module: `thermal_trip_monitor`

## Requirements
- R1: After reset, status, interrupt mask and all level fields read as zero, and the interrupt output is low.
- R2: The alarm control word of channel c is at address 0x50+4c. Its alarm trip level is in bits 27:16 and its release level in bits 11:0. All other bits read as zero.
- R3: The shutdown control word of channel c is at address 0x60+4c. Its shutdown level is in bits 27:16 and all other bits read as zero. Unmapped addresses read as zero.
- R4: When channel c is not in alarm, a valid sample with code at or below its alarm level puts it in alarm and sets status bit c (address 0x44) on the following clock edge.
- R5: While a channel is in alarm, further hot samples set no new alarm status. The alarm state clears only on a valid sample whose code is strictly above the release level, and codes at or below the release level keep it.
- R6: Each valid sample with code at or below the channel's shutdown level sets status bit 4+c, whether or not that bit is already set.
- R7: A code presented without its valid strobe changes no status and no alarm state.
- R8: Writing to the status address clears each bit written as 1 and leaves bits written as 0. A status set and a clear of the same bit in the same cycle leave the bit set.
- R9: The interrupt mask at address 0x48 uses the same bit positions as status. The interrupt output is high exactly when some status bit and its mask bit are both 1.
- R10: Comparisons are unsigned. A code of 0x800 is not at or below a level of 0x7FF.
- R11: Channels are independent. A sample on one channel sets only that channel's status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | NCH | Per-channel sample strobe |
| smp_code | input | NCH*CW | Per-channel sample codes, channel c at bits c*CW+:CW |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr, same cycle |
| irq | output | 1 | Masked OR of status bits |

## Verification
A wrong alarm-state bit is hidden until the next valid sample on that channel. Only then does it appear, either as a missing alarm status bit after a release-and-reassert sequence or as a spurious bit while the channel should still be held. The table therefore walks one channel through trip, hold, release and re-trip codes, and it reads status right after each sample. A faulty compare or status update is visible at the status address, and on the interrupt line when masked in, one clock after the sample strobe.

// File: rtl/thermal_trip_pkg.sv
package thermal_trip_pkg;
  localparam int unsigned TT_STATUS_OFS = 'h44;
  localparam int unsigned TT_MASK_OFS   = 'h48;
  localparam int unsigned TT_ALARM_BASE = 'h50;
  localparam int unsigned TT_SHUT_BASE  = 'h60;
  localparam int unsigned TT_CH_STRIDE  = 4;
  localparam int unsigned TT_HOT_LSB    = 16;
  localparam int unsigned TT_REL_LSB    = 0;
  localparam int unsigned TT_SHUT_BIT0  = 4;
endpackage

// File: rtl/trip_channel.sv
module trip_channel #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [CW-1:0] code,
  input  logic [CW-1:0] alarm_lvl,
  input  logic [CW-1:0] rel_lvl,
  input  logic [CW-1:0] shut_lvl,
  output logic          alarm_evt,
  output logic          shut_evt,
  output logic          in_alarm
);
  // Hotter means smaller code: "reached" is an unsigned at-or-below test.
  function automatic logic reached(input logic [CW-1:0] c, input logic [CW-1:0] lvl);
    return c <= lvl;
  endfunction

  function automatic logic released(input logic [CW-1:0] c, input logic [CW-1:0] lvl);
    return c > lvl;
  endfunction

  logic hot_now, rel_now;
  assign hot_now   = valid && reached(code, alarm_lvl);
  assign rel_now   = valid && released(code, rel_lvl);
  assign alarm_evt = !in_alarm && hot_now;
  assign shut_evt  = valid && reached(code, shut_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_alarm <= 1'b0;
    else if (alarm_evt) in_alarm <= 1'b1;
    else if (in_alarm && rel_now) in_alarm <= 1'b0;
  end

  a_r4_trip_enters_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> in_alarm);
  a_r5_hold_below_release: assert property (@(posedge clk) disable iff (!rst_n)
    (in_alarm && valid && (code <= rel_lvl)) |=> in_alarm);
  a_r5_no_event_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    in_alarm |-> !alarm_evt);
  a_r7_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(in_alarm));
endmodule

// File: rtl/trip_regs.sv
module trip_regs
  import thermal_trip_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 12,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NCH-1:0]    alarm_evt,
  input  logic [NCH-1:0]    shut_evt,
  output logic [NCH*CW-1:0] alarm_lvl,
  output logic [NCH*CW-1:0] rel_lvl,
  output logic [NCH*CW-1:0] shut_lvl,
  output logic              irq
);
  function automatic logic [AW-1:0] alarm_addr(input int ch);
    return AW'(TT_ALARM_BASE + TT_CH_STRIDE * ch);
  endfunction
  function automatic logic [AW-1:0] shut_addr(input int ch);
    return AW'(TT_SHUT_BASE + TT_CH_STRIDE * ch);
  endfunction

  logic              unused_wdata;
  logic [NCH-1:0]    a_st, s_st, a_msk, s_msk;
  logic              st_wr, msk_wr;
  logic [NCH-1:0]    a_clr, s_clr;

  assign unused_wdata = ^reg_wdata;
  assign st_wr  = reg_wr && (reg_addr == AW'(TT_STATUS_OFS));
  assign msk_wr = reg_wr && (reg_addr == AW'(TT_MASK_OFS));
  assign a_clr  = st_wr ? reg_wdata[NCH-1:0] : '0;
  assign s_clr  = st_wr ? reg_wdata[TT_SHUT_BIT0 +: NCH] : '0;

  // Sticky status: a new event outranks a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_st <= '0;
      s_st <= '0;
    end else begin
      a_st <= (a_st & ~a_clr) | alarm_evt;
      s_st <= (s_st & ~s_clr) | shut_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_msk <= '0;
      s_msk <= '0;
    end else if (msk_wr) begin
      a_msk <= reg_wdata[NCH-1:0];
      s_msk <= reg_wdata[TT_SHUT_BIT0 +: NCH];
    end
  end

  assign irq = |{a_st & a_msk, s_st & s_msk};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lvl
    logic [CW-1:0] hot_q, rel_q, shut_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hot_q <= '0;
        rel_q <= '0;
      end else if (reg_wr && reg_addr == alarm_addr(ch)) begin
        hot_q <= reg_wdata[TT_HOT_LSB +: CW];
        rel_q <= reg_wdata[TT_REL_LSB +: CW];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shut_q <= '0;
      else if (reg_wr && reg_addr == shut_addr(ch)) shut_q <= reg_wdata[TT_HOT_LSB +: CW];
    end
    assign alarm_lvl[ch*CW +: CW] = hot_q;
    assign rel_lvl[ch*CW +: CW]   = rel_q;
    assign shut_lvl[ch*CW +: CW]  = shut_q;

    a_r6_shut_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      shut_evt[ch] |=> s_st[ch]);
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && reg_wdata[ch] && !alarm_evt[ch]) |=> !a_st[ch]);
    a_r8_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (a_st[ch] && !(st_wr && reg_wdata[ch])) |=> a_st[ch]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(TT_STATUS_OFS)) begin
      reg_rdata[NCH-1:0] = a_st;
      reg_rdata[TT_SHUT_BIT0 +: NCH] = s_st;
    end
    if (reg_addr == AW'(TT_MASK_OFS)) begin
      reg_rdata[NCH-1:0] = a_msk;
      reg_rdata[TT_SHUT_BIT0 +: NCH] = s_msk;
    end
    for (int ch = 0; ch < NCH; ch++) begin
      if (reg_addr == alarm_addr(ch)) begin
        reg_rdata[TT_HOT_LSB +: CW] = alarm_lvl[ch*CW +: CW];
        reg_rdata[TT_REL_LSB +: CW] = rel_lvl[ch*CW +: CW];
      end
      if (reg_addr == shut_addr(ch))
        reg_rdata[TT_HOT_LSB +: CW] = shut_lvl[ch*CW +: CW];
    end
  end

  a_r9_irq_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|alarm_evt) || (|shut_evt) || msk_wr));
endmodule

// File: rtl/thermal_trip_monitor.sv
module thermal_trip_monitor #(
  parameter int NCH = 3,
  parameter int CW  = 12,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    smp_valid,
  input  logic [NCH*CW-1:0] smp_code,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic [NCH-1:0]    alarm_evt, shut_evt, in_alarm;
  logic [NCH*CW-1:0] alarm_lvl, rel_lvl, shut_lvl;

  trip_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) regs_i (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .alarm_evt, .shut_evt, .alarm_lvl, .rel_lvl, .shut_lvl, .irq
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    trip_channel #(.CW(CW)) chan_i (
      .clk, .rst_n,
      .valid     (smp_valid[ch]),
      .code      (smp_code[ch*CW +: CW]),
      .alarm_lvl (alarm_lvl[ch*CW +: CW]),
      .rel_lvl   (rel_lvl[ch*CW +: CW]),
      .shut_lvl  (shut_lvl[ch*CW +: CW]),
      .alarm_evt (alarm_evt[ch]),
      .shut_evt  (shut_evt[ch]),
      .in_alarm  (in_alarm[ch])
    );
  end

  a_r11_event_needs_own_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((alarm_evt | shut_evt) & ~smp_valid) == '0);
  a_r1_irq_low_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq);
endmodule

// File: tb/thermal_trip_monitor_tb_top.sv
module thermal_trip_monitor_tb_top;
  localparam int NCH = 3;
  localparam int CW  = 12;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam logic [AW-1:0] ST = 8'h44, MSK = 8'h48;
  // {code applied to channel 0, expected status byte}; ch0 trip 0x400, release 0x500, shutdown 0x200
  localparam logic [19:0] VEC [11] = '{
    {12'h600, 8'h00}, {12'h400, 8'h01}, {12'h450, 8'h00}, {12'h3FF, 8'h00},
    {12'h1FF, 8'h10}, {12'h501, 8'h00}, {12'h480, 8'h00}, {12'h400, 8'h01},
    {12'h200, 8'h10}, {12'h800, 8'h00}, {12'h000, 8'h11}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] smp_valid = '0;
  logic [NCH*CW-1:0] smp_code = '0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  thermal_trip_monitor #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) dut_i (
    .clk, .rst_n, .smp_valid, .smp_code, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push(input int ch, input logic [CW-1:0] c);
    @(negedge clk); smp_valid[ch] = 1'b1; smp_code[ch*CW +: CW] = c;
    @(negedge clk); smp_valid = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(ST, v);    chk("R1 status", v, 32'h0);
    rd(MSK, v);   chk("R1 mask", v, 32'h0);
    rd(8'h54, v); chk("R1 levels", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 / R3 field placement and unmapped reads
    wr(8'h58, 32'hFFFF_FFFF); rd(8'h58, v); chk("R2 alarm word", v, 32'h0FFF_0FFF);
    wr(8'h68, 32'hFFFF_FFFF); rd(8'h68, v); chk("R3 shutdown word", v, 32'h0FFF_0000);
    rd(8'h90, v); chk("R3 unmapped", v, 32'h0);

    // R4 R5 R6 table on channel 0
    wr(8'h50, 32'h0400_0500);
    wr(8'h60, 32'h0200_0000);
    for (int i = 0; i < 11; i++) begin
      push(0, VEC[i][19:8]);
      rd(ST, v);
      chk($sformatf("R4 R5 R6 vector %0d", i), v, {24'h0, VEC[i][7:0]});
      wr(ST, 32'hFF);
    end

    // R7 strobe-less codes are ignored
    wr(8'h54, 32'h0FFF_0FFF);
    @(negedge clk); smp_code[CW +: CW] = '0;
    repeat (3) @(negedge clk);
    rd(ST, v); chk("R7 no strobe", v, 32'h0);

    // R11 only channel 1 bits
    push(1, 12'h000);
    rd(ST, v); chk("R11 channel 1 only", v, 32'h22);

    // R8 clear semantics
    wr(ST, 32'h0); rd(ST, v); chk("R8 write zero keeps", v, 32'h22);
    wr(ST, 32'h22); rd(ST, v); chk("R8 clear", v, 32'h0);
    @(negedge clk);
    smp_valid[1] = 1'b1; smp_code[CW +: CW] = '0;
    reg_wr = 1'b1; reg_addr = ST; reg_wdata = 32'h20;
    @(negedge clk); smp_valid = '0; reg_wr = 1'b0;
    rd(ST, v); chk("R8 set beats clear", v, 32'h20);

    // R9 masked interrupt
    chk("R9 irq unmasked", {31'h0, irq}, 32'h0);
    wr(MSK, 32'h02); #1 chk("R9 irq other bit", {31'h0, irq}, 32'h0);
    wr(MSK, 32'h20); #1 chk("R9 irq on", {31'h0, irq}, 32'h1);
    rd(MSK, v); chk("R9 mask readback", v, 32'h20);
    wr(ST, 32'h20); #1 chk("R9 irq off after clear", {31'h0, irq}, 32'h0);
    wr(MSK, 32'h0);

    // R10 unsigned compare on channel 2
    wr(8'h58, 32'h07FF_07FF);
    wr(8'h68, 32'h07FF_0000);
    push(2, 12'h800);
    rd(ST, v); chk("R10 0x800 not hot", v, 32'h0);
    push(2, 12'h7FF);
    rd(ST, v); chk("R10 0x7FF hot", v, 32'h44);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule